// File: doc/BRIEF.md
# UART Receive Path with Error-Tagged FIFO and Line Status

This block is the receive half of an asynchronous serial port. It oversamples the serial input with an external sample tick (16 ticks per bit time) and assembles characters of 5 to 8 data bits, least significant bit first, with an optional parity bit of even or odd sense. A start bit counts only if the line is still low at mid-bit. A zero found where the stop bit should be is recorded as a framing error, and that zero is then treated as the start bit of the next character.

Each completed character goes into a 16-entry receive queue together with its own parity-error and framing-error tags. The tags appear in the status register only while their character is at the head of the queue. With the queue disabled, the block uses a single holding register instead. Software reads either the receive buffer, which pops the head, or a status word. Reading the status word clears the error flags.

Top module: `uart_rx_lsr`

## Requirements
- R1: A low line seen on a sample tick starts a character only if the line is still low 8 ticks later (mid start bit). Otherwise the receiver returns to idle and stores nothing.
- R2: Data bits are sampled at mid-bit, least significant first. Their count is 5 + `word_len` (0..3). Unused upper bits of the stored byte read as zero.
- R3: When `par_on` is 1, one parity bit follows the data. With `par_even` = 1 the data and parity bits together must hold an even number of ones; with `par_even` = 0 an odd number. A mismatch tags the character with a parity error.
- R4: A zero sampled at the stop-bit position tags the character with a framing error. The character is still stored.
- R5: In queue mode, status bit 2 (parity error) and bit 3 (framing error) show the tags of the head character only. They change as characters are popped.
- R6: In queue mode, a character completed while 16 entries are held sets the overrun flag in that cycle. The character is dropped and the queue contents are unchanged.
- R7: With `fifo_on` = 0, a character completed while the holding register is unread replaces the old one and sets the overrun flag.
- R8: A status read (`rd_sel` = 1) clears the overrun flag. It also clears the parity and framing error indications for the current head character.
- R9: Data ready (status bit 0, `data_ready`) is 1 whenever at least one character is stored. It clears only after the last stored character has been read.
- R10: After a framing error the receiver checks the line again on the next tick. If the line is low, it receives the following data bits as a new character without waiting for a fresh start edge.
- R11: After reset the queue is empty, the receiver is idle and every status bit is 0.
- R12: The status word holds data ready in bit 0, overrun in bit 1, parity error in bit 2, framing error in bit 3, and zeros in bits 7:4. A buffer read with nothing stored returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| fifo_on | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| par_on | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| word_len | input | 2 | Data bits minus 5 |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = receive buffer (pops), 1 = status word |
| rd_data | output | 8 | Read data, valid combinationally while rd_en is applied |
| data_ready | output | 1 | At least one character stored |
| overrun_err | output | 1 | Overrun flag |
| parity_err | output | 1 | Head character has a parity error |
| framing_err | output | 1 | Head character has a framing error |

## Verification
The bench sends a character with a bad parity bit between two clean ones. A design that latches the error globally, rather than tying it to the head, would show the flag too early or keep it after the pop. A bad stop bit is followed at once by the data of a second character. A receiver that waits for a new falling edge would lose or shift the second byte. Seventeen characters are sent into the queue without any reads: a design that overwrites the tail or drops the wrong entry would return wrong bytes on drain. A three-tick low glitch and a replaced holding register in single-register mode cover false starts and the non-queue overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_VERIFY
  } rx_state_t;

  // number of data bits for a word length code
  function automatic logic [3:0] data_bits(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

  // 1 when data plus parity bit do not match the selected sense
  function automatic logic parity_bad(input logic [7:0] d, input logic pbit,
                                      input logic even);
    return (^d) ^ pbit ^ ~even;
  endfunction

  function automatic logic [7:0] status_word(input logic dr, input logic ovr,
                                             input logic pe, input logic fe);
    return {4'b0000, fe, pe, ovr, dr};
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] wlen,
  input  logic      par_en,
  input  logic      par_even,
  output logic      frame_valid,
  output rx_entry_t frame
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;
  logic          par_bit;
  logic [3:0]    nbits;
  logic          bit_sample;

  assign nbits      = data_bits(wlen);
  assign bit_sample = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (tick) begin
      unique case (state)
        RX_IDLE: if (!rxd) begin
          state <= RX_START;
          cnt   <= '0;
        end
        RX_START: if (cnt == MID) begin
          if (!rxd) begin
            state   <= RX_DATA;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
          end else begin
            state <= RX_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        RX_DATA: if (cnt == LAST) begin
          cnt            <= '0;
          shreg[bit_idx] <= rxd;
          if ({1'b0, bit_idx} == nbits - 4'd1) state <= par_en ? RX_PAR : RX_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RX_PAR: if (cnt == LAST) begin
          cnt     <= '0;
          par_bit <= rxd;
          state   <= RX_STOP;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RX_STOP: if (cnt == LAST) begin
          cnt   <= '0;
          state <= rxd ? RX_IDLE : RX_VERIFY;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RX_VERIFY: if (!rxd) begin
          // one tick already spent past mid-bit
          state   <= RX_DATA;
          cnt     <= CW'(1);
          bit_idx <= '0;
          shreg   <= '0;
        end else begin
          state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign frame_valid = bit_sample && (state == RX_STOP);
  assign frame.data  = shreg;
  assign frame.fe    = !rxd;
  assign frame.pe    = par_en && parity_bad(shreg, par_bit, par_even);

  assert_glitch_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state == RX_START && cnt == MID && rxd) |=> state == RX_IDLE);

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ((frame.data >> nbits) == 8'd0));

  assert_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame.fe) |=> state == RX_VERIFY);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  logic      replace,
  input  rx_entry_t wdata,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == NW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    else if (replace && !empty) mem[rd_ptr] <= wdata;
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));

  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       sample_tick,
  input  logic       fifo_on,
  input  logic       par_on,
  input  logic       par_even,
  input  logic [1:0] word_len,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       framing_err
);
  localparam int NW = $clog2(DEPTH + 1);

  rx_entry_t   frame, head;
  logic        frame_valid, empty, full;
  logic [NW-1:0] count;

  // named internal events
  logic buf_rd, lsr_rd, pop, push, replace, ovr_set, head_change;
  logic ovr_q, err_ack;

  uart_rx_deser #(.OSR(OSR)) u_deser (
    .clk, .rst_n, .tick(sample_tick), .rxd(rx_line), .wlen(word_len),
    .par_en(par_on), .par_even, .frame_valid, .frame
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .push, .pop, .replace, .wdata(frame),
    .head, .empty, .full, .count
  );

  assign buf_rd  = rd_en && !rd_sel;
  assign lsr_rd  = rd_en && rd_sel;
  assign pop     = buf_rd && !empty;
  assign push    = frame_valid && (fifo_on ? (!full || pop) : (empty || pop));
  assign replace = frame_valid && !fifo_on && !empty && !pop;
  assign ovr_set = frame_valid && !pop && (fifo_on ? full : !empty);
  assign head_change = pop || (push && empty) || replace;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q   <= 1'b0;
      err_ack <= 1'b0;
    end else begin
      if (ovr_set)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (head_change) err_ack <= 1'b0;
      else if (lsr_rd) err_ack <= 1'b1;
    end
  end

  assign data_ready  = !empty;
  assign overrun_err = ovr_q;
  assign parity_err  = !empty && head.pe && !err_ack;
  assign framing_err = !empty && head.fe && !err_ack;

  assign rd_data = rd_sel ? status_word(data_ready, overrun_err, parity_err, framing_err)
                          : (empty ? 8'd0 : head.data);

  assert_fifo_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && fifo_on && full && !rd_en) |=> (overrun_err && $stable(count)));

  assert_hold_replace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !fifo_on && data_ready && !rd_en) |=> (overrun_err && data_ready));

  assert_lsr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !frame_valid) |=> (!overrun_err && !parity_err && !framing_err));

  assert_last_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && count == NW'(1) && !frame_valid) |=> !data_ready);

  assert_reset_state_R11: assert property (@(posedge clk)
    !rst_n |=> (!data_ready && !overrun_err && !parity_err && !framing_err));

endmodule

// File: tb/tb_uart_rx_lsr.sv
module tb_uart_rx_lsr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic sample_tick;
  logic fifo_on = 1'b1, par_on = 1'b0, par_even = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic data_ready, overrun_err, parity_err, framing_err;
  logic [1:0] tdiv;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 1'b0;

  // reference model: {fe, pe, data}
  logic [9:0] q[$];
  bit ovr_m = 1'b0, ack_m = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= 2'd0; else tdiv <= tdiv + 2'd1;
  assign sample_tick = (tdiv == 2'd3);

  uart_rx_lsr dut (
    .clk, .rst_n, .rx_line, .sample_tick, .fifo_on, .par_on, .par_even,
    .word_len, .rd_en, .rd_sel, .rd_data, .data_ready, .overrun_err,
    .parity_err, .framing_err
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    bit h = q.size() > 0;
    return {4'b0, h && q[0][9] && !ack_m, h && q[0][8] && !ack_m, ovr_m, h};
  endfunction

  // continuous comparison of the status outputs when the line is settled
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [7:0] s;
      s = exp_status();
      chk("R9 data_ready", data_ready, s[0]);
      chk("R8 overrun_err", overrun_err, s[1]);
      chk("R5 parity_err", parity_err, s[2]);
      chk("R5 framing_err", framing_err, s[3]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic void model_push(input logic [9:0] e);
    if (fifo_on) begin
      if (q.size() < 16) begin
        if (q.size() == 0) ack_m = 1'b0;
        q.push_back(e);
      end else ovr_m = 1'b1;
    end else if (q.size() == 0) begin
      q.push_back(e); ack_m = 1'b0;
    end else begin
      q[0] = e; ack_m = 1'b0; ovr_m = 1'b1;
    end
  endfunction

  task automatic read_status(input string req);
    logic [7:0] v;
    @(negedge clk); rd_en = 1'b1; rd_sel = 1'b1; #1;
    v = rd_data;
    chk(req, v, exp_status());
    ovr_m = 1'b0;
    if (q.size() > 0) ack_m = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic read_buf(input string req);
    logic [7:0] v;
    @(negedge clk); rd_en = 1'b1; rd_sel = 1'b0; #1;
    v = rd_data;
    chk(req, v, (q.size() > 0) ? int'(q[0][7:0]) : 0);
    if (q.size() > 0) begin void'(q.pop_front()); ack_m = 1'b0; end
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (64) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [7:0] d, input int nb, input logic even);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return even ? p : ~p;
  endfunction

  function automatic logic [7:0] mask(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  task automatic send_body(input logic [7:0] d, input logic pbit, input logic stopb);
    int nb = 5 + int'(word_len);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par_on) drive_bit(pbit);
    drive_bit(stopb);
  endtask

  // complete character followed by one idle bit; flip_par injects a parity error
  task automatic send_char(input logic [7:0] d, input bit flip_par);
    int nb = 5 + int'(word_len);
    logic pb = good_par(d, nb, par_even) ^ flip_par;
    cmp_en = 1'b0;
    @(negedge clk);
    drive_bit(1'b0);
    send_body(d, pb, 1'b1);
    drive_bit(1'b1);
    model_push({1'b0, par_on && flip_par, mask(d, nb)});
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11 / R12: reset state
    chk("R11 data_ready after reset", data_ready, 0);
    chk("R11 overrun_err after reset", overrun_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    read_status("R11 status after reset");
    read_buf("R12 empty buffer read");

    // R2: 8 bits, no parity
    send_char(8'hA5, 1'b0);
    read_status("R9 status after one char");
    read_buf("R2 8-bit data");
    read_status("R9 status after drain");

    // R2/R3: 5 bits even parity, 7 bits odd parity
    word_len = 2'd0; par_on = 1'b1; par_even = 1'b1;
    send_char(8'hF3, 1'b0);
    read_buf("R2 5-bit padded");
    word_len = 2'd2; par_even = 1'b0;
    send_char(8'h5A, 1'b0);
    read_status("R3 odd parity clean");
    read_buf("R2 7-bit padded");

    // R3/R5/R8: parity error travels with its character
    word_len = 2'd3; par_even = 1'b1;
    send_char(8'h31, 1'b0);
    send_char(8'h32, 1'b1);
    send_char(8'h33, 1'b0);
    read_status("R5 head clean before bad char");
    read_buf("R5 first char");
    read_status("R3 parity error at head");
    read_status("R8 parity cleared by status read");
    read_buf("R5 bad-parity char data");
    read_status("R5 next head clean");
    read_buf("R5 third char");

    // R4/R10: bad stop bit acts as start of next character
    par_on = 1'b0;
    cmp_en = 1'b0;
    @(negedge clk);
    drive_bit(1'b0);
    send_body(8'h3C, 1'b0, 1'b0);
    send_body(8'hC3, 1'b0, 1'b1);
    drive_bit(1'b1);
    model_push({1'b1, 1'b0, 8'h3C});
    model_push({1'b0, 1'b0, 8'hC3});
    cmp_en = 1'b1;
    read_status("R4 framing error reported");
    read_buf("R4 framed char kept");
    read_status("R10 resync char clean");
    read_buf("R10 resync char data");

    // R1: short low glitch is rejected
    cmp_en = 1'b0;
    @(negedge clk); rx_line = 1'b0;
    repeat (12) @(negedge clk);
    drive_bit(1'b1);
    drive_bit(1'b1);
    cmp_en = 1'b1;
    read_status("R1 glitch stores nothing");

    // R6: 17 characters into a 16-deep queue
    for (int k = 0; k < 17; k++) send_char(8'(8'h40 + k), 1'b0);
    read_status("R6 overrun with full queue");
    read_status("R8 overrun cleared");
    for (int k = 0; k < 16; k++) read_buf("R6 queued data");
    read_status("R9 empty after drain");
    read_buf("R6 dropped char absent");

    // R7: single holding register
    fifo_on = 1'b0;
    send_char(8'h11, 1'b0);
    send_char(8'h22, 1'b0);
    read_status("R7 overrun in holding mode");
    read_buf("R7 newest char kept");
    read_status("R9 holding register empty");

    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule